// File: doc/BRIEF.md
# Receive Delay Line Phase Tuner

This block is a hardware sequencer that sets up a programmable receive-clock delay line for a high-speed card interface and then chooses the sampling phase. A single start pulse launches the sequence. The first part is a calibration pass, used only by the calibrating variant. It steps the delay-unit code upward with the tap select parked at its top code and the sampler switched on. It stops at the first unit whose reported line length is non-zero and fits in eleven bits. The highest set bit of that length becomes the last usable phase.

The block then visits every phase from 0 to that last phase with the sampler off. For each phase it asks the command engine for one tuning-block transfer and records whether it passed. Then it programs the centre of the longest unbroken run of passing phases. A second variant skips calibration. It sweeps a fixed range of 33 tap codes (0 to 32), and after every tap write it waits for an acknowledge from the delay line, bounded by a timeout. Tuning is carried out only in the two fastest timing modes and only when the card clock is above 50 MHz. In every other case the block reports completion straight away.

Timeouts are counted in block-clock cycles as microseconds times a cycles-per-microsecond parameter. The `done` output pulses for one cycle at the end of every run, and `err` reports the outcome at that point.

Top module: `dly_tune_engine`

## Requirements
- R1: If `speed_mode` is neither 4 (SDR104) nor 5 (HS200), or `card_clk_fast` is 0, a start produces a `done` pulse on the second clock edge after start is sampled, with `err` low, no `tune_req`, and `dl_unit`/`dl_sel` unchanged.
- R2: The calibrating variant visits unit codes 0, 1, 2, ... in steps of one. During each step it holds `dl_sel` at 12 and keeps `dl_sampler` and `dl_enable` high.
- R3: A unit code whose `len_valid` does not arrive within CAL_TO_US × CYC_PER_US cycles is skipped, and the sweep moves on to the next code.
- R4: A unit code is accepted when `len_valid` is seen with `len_value` non-zero and below 2048. Zero and 2048 or above are rejected. The accepted code stays on `dl_unit` after the run.
- R5: If no code up to 127 is accepted, the run ends with `done` and `err` high and no tuning transfer is requested.
- R6: The phase sweep covers phases 0 up to the bit index of the top set bit of the accepted length, inclusive. It makes exactly one request per phase, in increasing order, with `dl_sel` equal to the phase and `dl_sampler` low.
- R7: `tune_req` stays high until `tune_resp_valid` is seen. `tune_pass` is taken in that same cycle.
- R8: The final phase is the end phase of the longest passing run minus half its length, rounded down. Among runs of equal length the earliest one wins.
- R9: If no phase passes, the run ends with `err` high.
- R10: `done` is high for exactly one cycle. `err` is valid with `done`, holds until the next start, and is cleared on that start. A successful run leaves `dl_sel` at the final phase, `dl_enable` high and `dl_sampler` low.
- R11: A start pulse while a run is in progress is ignored: only one `done` is produced and the result does not change.
- R12: The fixed variant skips calibration and sweeps phases 0 to 32 inclusive. It waits for `tap_ack` after each tap write, including the final one, before going on.
- R13: In the fixed variant, a `tap_ack` that does not arrive within ACK_TO_US × CYC_PER_US cycles ends the run with `err` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only when idle |
| speed_mode | input | 3 | Bus timing mode; 4 = SDR104, 5 = HS200 |
| card_clk_fast | input | 1 | High when the card clock is above 50 MHz |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Run outcome, valid with done |
| dl_enable | output | 1 | Delay line enable |
| dl_sampler | output | 1 | Delay line length sampler enable |
| dl_unit | output | 7 | Delay unit code |
| dl_sel | output | 6 | Tap select code |
| len_valid | input | 1 | Measured length is valid |
| len_value | input | 12 | Measured delay line length |
| tap_ack | input | 1 | Tap select acknowledge (fixed variant) |
| tune_req | output | 1 | Request one tuning-block transfer |
| tune_resp_valid | input | 1 | Tuning transfer result strobe |
| tune_pass | input | 1 | Tuning transfer passed |

## Verification
A run-length or end-phase register that is out of step shows only at the end of a run, as a wrong `dl_sel` on the `done` pulse. Window patterns with ties, single passes and full passes are therefore chosen so that every off-by-one lands on a different final code. A miscounted phase counter shows sooner, as a wrong number of `tune_req` rises or a `dl_sel` that differs from the request index at the moment a request rises. A calibration sweep that skips or repeats a unit shows at once as a non-unit step on `dl_unit` while the sampler is on, and in the end as the wrong accepted unit.

// File: rtl/dly_tune_pkg.sv
package dly_tune_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAL_WAIT,
    ST_CAL_NEXT,
    ST_PH_SET,
    ST_PH_ACK,
    ST_PH_REQ,
    ST_PH_EVAL,
    ST_FIN_ACK,
    ST_OK,
    ST_FAIL
  } tune_state_e;

  localparam logic [2:0] SPEED_SDR104 = 3'd4;
  localparam logic [2:0] SPEED_HS200  = 3'd5;

endpackage

// File: rtl/dly_tune_timer.sv
module dly_tune_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIM);

  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (expired && !clear) |=> expired);
endmodule

// File: rtl/dly_tune_msb.sv
module dly_tune_msb #(
  parameter int LEN_W = 12,
  parameter int IDX_W = 6
) (
  input  logic [LEN_W-1:0] len,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < LEN_W; i++) begin
      if (len[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dly_tune_window.sv
module dly_tune_window #(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [SEL_W-1:0] phase,
  output logic             any_pass,
  output logic [SEL_W-1:0] final_phase
);
  localparam int RUN_W = SEL_W + 1;

  logic [RUN_W-1:0] cur_q, best_q;
  logic [SEL_W-1:0] end_q;
  logic [RUN_W-1:0] cur_inc;

  assign cur_inc = cur_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (upd) begin
      if (pass) begin
        cur_q <= cur_inc;
        if (cur_inc > best_q) begin
          best_q <= cur_inc;
          end_q  <= phase;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  assign any_pass    = (best_q != '0);
  assign final_phase = end_q - SEL_W'(best_q >> 1);

  assert_run_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cur_q <= best_q);
  assert_best_grows_R8: assert property (@(posedge clk) disable iff (rst || clr)
    !upd |=> $stable(best_q));
endmodule

// File: rtl/dly_tune_engine.sv
module dly_tune_engine
  import dly_tune_pkg::*;
#(
  parameter int FIXED_TAPS_MODE = 0,
  parameter int UNIT_W          = 7,
  parameter int UNIT_MAX        = 127,
  parameter int SEL_W           = 6,
  parameter int SEL_CAL         = 12,
  parameter int LEN_W           = 12,
  parameter int LEN_OK_BITS     = 11,
  parameter int FIXED_TAPS      = 32,
  parameter int CYC_PER_US      = 100,
  parameter int CAL_TO_US       = 1000,
  parameter int ACK_TO_US       = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        speed_mode,
  input  logic              card_clk_fast,
  output logic              done,
  output logic              err,
  output logic              dl_enable,
  output logic              dl_sampler,
  output logic [UNIT_W-1:0] dl_unit,
  output logic [SEL_W-1:0]  dl_sel,
  input  logic              len_valid,
  input  logic [LEN_W-1:0]  len_value,
  input  logic              tap_ack,
  output logic              tune_req,
  input  logic              tune_resp_valid,
  input  logic              tune_pass
);
  localparam int TMO_CYC = (FIXED_TAPS_MODE != 0) ? ACK_TO_US * CYC_PER_US
                                                  : CAL_TO_US * CYC_PER_US;
  localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(UNIT_MAX);
  localparam logic [SEL_W-1:0]  SEL_TOP   = SEL_W'(SEL_CAL);
  localparam logic [SEL_W-1:0]  TAP_LAST  = SEL_W'(FIXED_TAPS);
  localparam bit                FIXED     = (FIXED_TAPS_MODE != 0);

  tune_state_e state_q;
  logic [UNIT_W-1:0] unit_q;
  logic [SEL_W-1:0]  sel_q, phase_q, maxph_q;
  logic en_q, samp_q, req_q, done_q, err_q;

  logic mode_ok, len_ok, tmr_clr, tmr_exp, win_clr, win_upd, any_pass;
  logic [SEL_W-1:0] len_msb, final_phase;

  assign mode_ok = card_clk_fast &&
                   (speed_mode == SPEED_SDR104 || speed_mode == SPEED_HS200);
  assign len_ok  = (len_value != '0) && (len_value[LEN_W-1:LEN_OK_BITS] == '0);

  assign tmr_clr = !(state_q == ST_CAL_WAIT || state_q == ST_PH_ACK ||
                     state_q == ST_FIN_ACK);
  assign win_clr = (state_q == ST_IDLE) && start;
  assign win_upd = (state_q == ST_PH_REQ) && tune_resp_valid;

  dly_tune_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .clear(tmr_clr), .expired(tmr_exp)
  );

  dly_tune_msb #(.LEN_W(LEN_W), .IDX_W(SEL_W)) u_msb (
    .len(len_value), .idx(len_msb)
  );

  dly_tune_window #(.SEL_W(SEL_W)) u_window (
    .clk(clk), .rst(rst), .clr(win_clr), .upd(win_upd), .pass(tune_pass),
    .phase(phase_q), .any_pass(any_pass), .final_phase(final_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      unit_q  <= '0;
      sel_q   <= '0;
      phase_q <= '0;
      maxph_q <= '0;
      en_q    <= 1'b0;
      samp_q  <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            err_q <= 1'b0;
            if (!mode_ok) begin
              state_q <= ST_OK;
            end else if (FIXED) begin
              en_q    <= 1'b1;
              samp_q  <= 1'b0;
              phase_q <= '0;
              maxph_q <= TAP_LAST;
              state_q <= ST_PH_SET;
            end else begin
              unit_q  <= '0;
              sel_q   <= SEL_TOP;
              en_q    <= 1'b1;
              samp_q  <= 1'b1;
              state_q <= ST_CAL_WAIT;
            end
          end
        end
        ST_CAL_WAIT: begin
          if (len_valid) begin
            if (len_ok) begin
              maxph_q <= len_msb;
              samp_q  <= 1'b0;
              phase_q <= '0;
              state_q <= ST_PH_SET;
            end else begin
              state_q <= ST_CAL_NEXT;
            end
          end else if (tmr_exp) begin
            state_q <= ST_CAL_NEXT;
          end
        end
        ST_CAL_NEXT: begin
          if (unit_q == UNIT_LAST) begin
            state_q <= ST_FAIL;
          end else begin
            unit_q  <= unit_q + 1'b1;
            state_q <= ST_CAL_WAIT;
          end
        end
        ST_PH_SET: begin
          sel_q <= phase_q;
          if (FIXED) begin
            state_q <= ST_PH_ACK;
          end else begin
            req_q   <= 1'b1;
            state_q <= ST_PH_REQ;
          end
        end
        ST_PH_ACK: begin
          if (tap_ack) begin
            req_q   <= 1'b1;
            state_q <= ST_PH_REQ;
          end else if (tmr_exp) begin
            state_q <= ST_FAIL;
          end
        end
        ST_PH_REQ: begin
          if (tune_resp_valid) begin
            req_q <= 1'b0;
            if (phase_q == maxph_q) begin
              state_q <= ST_PH_EVAL;
            end else begin
              phase_q <= phase_q + 1'b1;
              state_q <= ST_PH_SET;
            end
          end
        end
        ST_PH_EVAL: begin
          if (!any_pass) begin
            state_q <= ST_FAIL;
          end else begin
            sel_q   <= final_phase;
            en_q    <= 1'b1;
            samp_q  <= 1'b0;
            state_q <= FIXED ? ST_FIN_ACK : ST_OK;
          end
        end
        ST_FIN_ACK: begin
          if (tap_ack) state_q <= ST_OK;
          else if (tmr_exp) state_q <= ST_FAIL;
        end
        ST_OK: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_FAIL: begin
          done_q  <= 1'b1;
          err_q   <= 1'b1;
          samp_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign err        = err_q;
  assign dl_enable  = en_q;
  assign dl_sampler = samp_q;
  assign dl_unit    = unit_q;
  assign dl_sel     = sel_q;
  assign tune_req   = req_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (tune_req && !tune_resp_valid) |=> tune_req);
  assert_req_sampler_off_R6: assert property (@(posedge clk) disable iff (rst)
    tune_req |-> (!dl_sampler && dl_sel <= maxph_q));
  assert_cal_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAL_WAIT) |-> (dl_sampler && dl_enable && dl_sel == SEL_TOP));
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAL_WAIT && $past(state_q) == ST_CAL_NEXT)
      |-> (dl_unit == $past(dl_unit) + 1'b1));
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

// File: tb/test_dly_tune_engine.sv
module test_dly_tune_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- instance A: calibrating variant ----------------
  logic start_a = 1'b0;
  logic [2:0] mode_a = 3'd4;
  logic fast_a = 1'b1;
  logic done_a, err_a, en_a, samp_a, req_a, resp_a = 1'b0, pass_a = 1'b0;
  logic [6:0] unit_a;
  logic [5:0] sel_a;
  logic lval_a;
  logic [11:0] len_a;
  int acc_u = 0;
  logic [11:0] acc_l = 12'h001;
  logic [63:0] pat_a = '0;

  dly_tune_engine #(.FIXED_TAPS_MODE(0), .CYC_PER_US(1), .CAL_TO_US(8),
                    .ACK_TO_US(8)) i_dly_tune_engine (
    .clk(clk), .rst(rst), .start(start_a), .speed_mode(mode_a),
    .card_clk_fast(fast_a), .done(done_a), .err(err_a), .dl_enable(en_a),
    .dl_sampler(samp_a), .dl_unit(unit_a), .dl_sel(sel_a),
    .len_valid(lval_a), .len_value(len_a), .tap_ack(1'b0),
    .tune_req(req_a), .tune_resp_valid(resp_a), .tune_pass(pass_a));

  // delay line model: units below acc_u either time out, report 2048 or 0
  logic [6:0] seen_u = '0;
  int lat_u = 0;
  always @(negedge clk) begin
    if (unit_a != seen_u) begin seen_u <= unit_a; lat_u <= 3; end
    else if (lat_u > 0) lat_u <= lat_u - 1;
  end
  always_comb begin
    if (int'(unit_a) == acc_u) len_a = acc_l;
    else if (int'(unit_a) > acc_u) len_a = 12'hA00;
    else if ((int'(unit_a) % 3) == 1) len_a = 12'h800;
    else len_a = 12'h000;
  end
  assign lval_a = samp_a && (unit_a == seen_u) && (lat_u == 0) &&
                  !((int'(unit_a) < acc_u) && ((int'(unit_a) % 3) == 0));

  int dly_a = 0;
  always @(negedge clk) begin
    if (resp_a) resp_a <= 1'b0;
    else if (req_a) begin
      if (dly_a == 2) begin resp_a <= 1'b1; pass_a <= pat_a[sel_a]; dly_a <= 0; end
      else dly_a <= dly_a + 1;
    end
  end

  // monitor A
  int nreq_a = 0, selbad_a = 0, sampbad_a = 0, calbad_a = 0, stepbad_a = 0;
  int ndone_a = 0, dlen_a = 0, dmax_a = 0;
  logic req_prev_a = 0;
  logic [6:0] unit_prev_a = '0;
  always @(negedge clk) begin
    req_prev_a <= req_a;
    unit_prev_a <= unit_a;
    if (req_a && !req_prev_a) begin
      if (int'(sel_a) != nreq_a) selbad_a <= selbad_a + 1;
      if (samp_a) sampbad_a <= sampbad_a + 1;
      nreq_a <= nreq_a + 1;
    end
    if (samp_a && (sel_a != 6'd12 || !en_a)) calbad_a <= calbad_a + 1;
    if (samp_a && unit_a != unit_prev_a && unit_a != 7'd0 &&
        unit_a != unit_prev_a + 7'd1) stepbad_a <= stepbad_a + 1;
    if (done_a) begin
      ndone_a <= ndone_a + 1;
      dlen_a <= dlen_a + 1;
      if (dlen_a + 1 > dmax_a) dmax_a <= dlen_a + 1;
    end else dlen_a <= 0;
  end

  function automatic int msb_of(input logic [11:0] v);
    int r = 0;
    for (int i = 0; i < 12; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic exp_win(input logic [63:0] p, input int maxp, output int best, output int fin);
    int cur = 0;
    int endp = 0;
    best = 0;
    for (int i = 0; i <= maxp; i++) begin
      if (p[i]) begin
        cur++;
        if (cur > best) begin best = cur; endp = i; end
      end else cur = 0;
    end
    fin = endp - best / 2;
  endtask

  task automatic run_a(input int u, input logic [11:0] l, input logic [63:0] p,
                       input logic [2:0] m, input logic f, input bit busy);
    int waited = 0;
    int best, fin, maxp;
    bit bypass, got_err;
    logic [6:0] u0;
    logic [5:0] s0;
    acc_u = u; acc_l = l; pat_a = p; mode_a = m; fast_a = f;
    nreq_a = 0; selbad_a = 0; sampbad_a = 0; calbad_a = 0; stepbad_a = 0;
    ndone_a = 0; dmax_a = 0;
    u0 = unit_a; s0 = sel_a;
    @(negedge clk); start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    chk(err_a == 1'b0, "R10 err cleared on start", err_a, 0);
    waited = 1;
    while (!done_a && waited < 20000) begin
      start_a = (busy && waited == 30);
      @(negedge clk);
      waited++;
    end
    start_a = 1'b0;
    got_err = err_a;
    bypass = !(f && (m == 3'd4 || m == 3'd5));
    repeat (4) @(negedge clk);
    chk(ndone_a == 1, "R10/R11 one done per run", ndone_a, 1);
    chk(dmax_a == 1, "R10 done width", dmax_a, 1);
    chk(err_a == got_err, "R10 err held", err_a, got_err);
    if (bypass) begin
      chk(waited == 2, "R1 bypass latency", waited, 2);
      chk(!got_err, "R1 bypass no error", got_err, 0);
      chk(nreq_a == 0, "R1 bypass no requests", nreq_a, 0);
      chk(unit_a == u0 && sel_a == s0, "R1 outputs unchanged", sel_a, s0);
    end else if (u > 127) begin
      chk(got_err, "R5 exhaust error", got_err, 1);
      chk(nreq_a == 0, "R5 no requests", nreq_a, 0);
      chk(stepbad_a == 0 && calbad_a == 0, "R2 sweep steps", stepbad_a, 0);
    end else begin
      maxp = msb_of(l);
      exp_win(p, maxp, best, fin);
      chk(unit_a == 7'(u), "R3/R4 accepted unit", unit_a, u);
      chk(stepbad_a == 0 && calbad_a == 0, "R2 sweep steps", stepbad_a + calbad_a, 0);
      chk(nreq_a == maxp + 1, "R6 request count", nreq_a, maxp + 1);
      chk(selbad_a == 0 && sampbad_a == 0, "R6/R7 phase order", selbad_a + sampbad_a, 0);
      if (best == 0) chk(got_err, "R9 no pass error", got_err, 1);
      else begin
        chk(!got_err, "R10 success no error", got_err, 0);
        chk(int'(sel_a) == fin, "R8 final phase", sel_a, fin);
        chk(en_a && !samp_a, "R10 final enables", {en_a, samp_a}, 2);
      end
    end
  endtask

  // ---------------- instance B: fixed tap variant ----------------
  logic start_b = 1'b0;
  logic done_b, err_b, en_b, samp_b, req_b, resp_b = 1'b0, pass_b = 1'b0;
  logic [6:0] unit_b;
  logic [5:0] sel_b;
  logic ack_b, ack_block = 1'b0;
  logic [63:0] pat_b = '0;

  dly_tune_engine #(.FIXED_TAPS_MODE(1), .CYC_PER_US(1), .CAL_TO_US(8),
                    .ACK_TO_US(8)) i_dly_tune_engine_fix (
    .clk(clk), .rst(rst), .start(start_b), .speed_mode(3'd5),
    .card_clk_fast(1'b1), .done(done_b), .err(err_b), .dl_enable(en_b),
    .dl_sampler(samp_b), .dl_unit(unit_b), .dl_sel(sel_b),
    .len_valid(1'b0), .len_value(12'h000), .tap_ack(ack_b),
    .tune_req(req_b), .tune_resp_valid(resp_b), .tune_pass(pass_b));

  logic [5:0] seen_s = '0;
  int lat_s = 0;
  always @(negedge clk) begin
    if (sel_b != seen_s) begin seen_s <= sel_b; lat_s <= 2; end
    else if (lat_s > 0) lat_s <= lat_s - 1;
  end
  assign ack_b = !ack_block && (sel_b == seen_s) && (lat_s == 0);

  int dly_b = 0;
  int nreq_b = 0, selbad_b = 0;
  logic req_prev_b = 0;
  always @(negedge clk) begin
    req_prev_b <= req_b;
    if (req_b && !req_prev_b) begin
      if (int'(sel_b) != nreq_b) selbad_b <= selbad_b + 1;
      nreq_b <= nreq_b + 1;
    end
    if (resp_b) resp_b <= 1'b0;
    else if (req_b) begin
      if (dly_b == 1) begin resp_b <= 1'b1; pass_b <= pat_b[sel_b]; dly_b <= 0; end
      else dly_b <= dly_b + 1;
    end
  end

  task automatic run_b(input logic [63:0] p, input bit block);
    int waited = 0;
    int best, fin;
    bit got_err;
    pat_b = p; ack_block = block; nreq_b = 0; selbad_b = 0;
    @(negedge clk); start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    while (!done_b && waited < 20000) begin @(negedge clk); waited++; end
    got_err = err_b;
    ack_block = 1'b0;
    repeat (3) @(negedge clk);
    if (block) begin
      chk(got_err, "R13 ack timeout error", got_err, 1);
      chk(nreq_b == 0, "R13 no request without ack", nreq_b, 0);
    end else begin
      exp_win(p, 32, best, fin);
      chk(nreq_b == 33, "R12 fixed sweep count", nreq_b, 33);
      chk(selbad_b == 0, "R12 fixed phase order", selbad_b, 0);
      chk(unit_b == 7'd0, "R12 no calibration", unit_b, 0);
      if (best == 0) chk(got_err, "R9 fixed no pass", got_err, 1);
      else begin
        chk(!got_err, "R12 fixed success", got_err, 0);
        chk(int'(sel_b) == fin, "R8/R12 fixed final", sel_b, fin);
      end
    end
  endtask

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_a && !err_a && !req_a && !en_a && !samp_a, "R10 reset outputs",
        {done_a, err_a, req_a, en_a, samp_a}, 0);
    chk(unit_a == 0 && sel_a == 0, "R10 reset codes", sel_a, 0);

    run_a(5, 12'h3FF, 64'h0000_0000_0000_01DA, 3'd4, 1'b1, 1'b0);
    run_a(0, 12'h001, 64'h1, 3'd5, 1'b1, 1'b0);
    run_a(17, 12'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd5, 1'b1, 1'b0);
    run_a(2, 12'h0A0, 64'h0000_0000_0000_00DB, 3'd4, 1'b1, 1'b0);
    run_a(3, 12'h040, 64'h0, 3'd4, 1'b1, 1'b0);
    run_a(9, 12'h011, 64'h1E, 3'd4, 1'b1, 1'b0);
    run_a(200, 12'h001, 64'h0, 3'd4, 1'b1, 1'b0);
    run_a(7, 12'h100, 64'h0000_0000_0000_01F8, 3'd4, 1'b1, 1'b1);
    run_a(4, 12'h010, 64'hF, 3'd2, 1'b1, 1'b0);
    run_a(4, 12'h010, 64'hF, 3'd4, 1'b0, 1'b0);
    run_a(1, 12'h7FF, 64'h0000_0000_0000_0600, 3'd5, 1'b1, 1'b0);

    run_b(64'h0000_0001_F0F0_3C3C, 1'b0);
    run_b(64'h0000_0001_0000_0000, 1'b0);
    run_b(64'h0000_0000_0000_0000, 1'b0);
    run_b(64'h0000_0000_0FFF_0000, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule